// File: doc/BRIEF.md
# Wide-to-Narrow Stream FIFO with Element Count

This block buffers a stream whose producer delivers wide words and whose consumer takes narrow elements. A wide word is a concatenation of `RATIO` narrow elements. The storage is a row of `RATIO` narrow lane FIFOs. A wide write pushes into every lane in the same cycle. Reads take one element at a time from the lanes in rotating order, so the consumer receives each wide word as `RATIO` consecutive elements, lowest-order element first.

Each lane FIFO knows only how full it is. The block therefore keeps its own count of stored narrow elements and reports it on `level`. The write side uses the same count to decide whether a whole wide word still fits.

A parameter places a two-entry skid buffer between the lane read logic and the output handshake. This breaks the timing path from the lane pointers to the consumer without reducing throughput. When the parameter is off, the output is driven combinationally from the selected lane.

Top module: `wide2narrow_fifo`

## Requirements
- R1: After a synchronous active-low reset, `out_valid` is 0, `level` is 0 and `in_ready` is 1.
- R2: A wide word is delivered as `RATIO` narrow elements, starting with bits `[NARROW_W-1:0]` (lane 0) and rising one lane at a time. Words leave in the order they were written.
- R3: `level` rises by `RATIO` on a write handshake and falls by 1 on a read handshake. When both happen in the same cycle, `level` changes by `RATIO-1`.
- R4: `in_ready` is 0 whenever `RATIO*LANE_DEPTH - level < RATIO`. While `in_ready` is 0, `in_valid` has no effect on `level` or on the data delivered.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` keeps its value on the next cycle.
- R6: With `SLICE_EN=0`, `out_valid` rises in the cycle right after the edge that accepts a word into an empty FIFO. With `SLICE_EN=1`, it rises one cycle later. In both cases `level` counts the elements held in the slice.
- R7: When the consumer holds `out_ready` at 1 and the producer writes as fast as `in_ready` allows, elements leave on every clock cycle with no gap, loss or duplication.
- R8: After the last lane the read order returns to lane 0, so successive words keep the order given in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Wide word offered |
| in_ready | output | 1 | Room for one whole wide word |
| in_data | input | NARROW_W*RATIO | Wide word, lane 0 in the low bits |
| out_valid | output | 1 | Narrow element available |
| out_ready | input | 1 | Consumer accepts the element |
| out_data | output | NARROW_W | Narrow element |
| level | output | clog2(RATIO*LANE_DEPTH+1) | Stored narrow elements, slice included |

## Verification
The hardest situation to reach is the slice holding both of its entries while the lanes keep refilling and the write side sits at the edge of its room check. In that state a wrong count or a skid slip would lose or repeat an element. The bench builds one instance with the slice and one without. It fills each to capacity, then pops single elements to watch `in_ready` return. It also runs bursts against an irregular `out_ready` pattern while a scoreboard and a cycle-by-cycle level model follow every handshake.

// File: rtl/w2n_pkg.sv
// Shared helpers for the wide-to-narrow FIFO.
package w2n_pkg;
    // Index width with a floor of one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/w2n_lane_fifo.sv
// One narrow lane: synchronous FIFO with a combinational read port.
// Assumes DEPTH is a power of two of at least 2.
// The parent never pushes when the lane is full and never pops when it is empty.
module w2n_lane_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] pop_data,
    output logic              empty,
    output logic              full
);
    localparam int AW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW:0]       wr_ptr, rd_ptr;

    // Store the incoming element.
    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr[AW-1:0]] <= push_data;
    end

    // Advance the pointers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
        end
    end

    assign pop_data = mem[rd_ptr[AW-1:0]];
    assign empty    = (wr_ptr == rd_ptr);
    assign full     = (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]) && (wr_ptr[AW] != rd_ptr[AW]);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/w2n_out_slice.sv
// Two-entry skid buffer on the narrow output.
// Registers valid and data toward the consumer and passes one element per clock.
// up_ready depends only on local state, which breaks the path back to the lane logic.
module w2n_out_slice #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic [DATA_W-1:0] up_data,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [DATA_W-1:0] dn_data
);
    logic              skid_v;
    logic [DATA_W-1:0] skid_d;

    assign up_ready = !skid_v;

    // Move data into the main stage, or park it in the skid stage on a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dn_valid <= 1'b0;
            skid_v   <= 1'b0;
            dn_data  <= '0;
            skid_d   <= '0;
        end else if (dn_ready || !dn_valid) begin
            if (skid_v) begin
                dn_data  <= skid_d;
                dn_valid <= 1'b1;
                skid_v   <= 1'b0;
            end else begin
                dn_valid <= up_valid;
                if (up_valid) dn_data <= up_data;
            end
        end else if (up_valid && !skid_v) begin
            skid_d <= up_data;
            skid_v <= 1'b1;
        end
    end

    // R7
    skid_order_chk: assert property (@(posedge clk) disable iff (!rst_n) skid_v |-> dn_valid);
    // R5
    slice_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid && !dn_ready |=> dn_valid && $stable(dn_data));
endmodule

// File: rtl/wide2narrow_fifo.sv
// Wide-write, narrow-read stream FIFO built from RATIO lane FIFOs.
// A write pushes all lanes at once. Reads pop the lanes in turn, starting at lane 0.
// An explicit counter tracks stored narrow elements, including the optional output slice.
// Assumes LANE_DEPTH is a power of two of at least 2.
module wide2narrow_fifo #(
    parameter int NARROW_W   = 8,
    parameter int RATIO      = 4,
    parameter int LANE_DEPTH = 4,
    parameter bit SLICE_EN   = 1'b0,
    localparam int WIDE_W    = NARROW_W * RATIO,
    localparam int CAP       = RATIO * LANE_DEPTH,
    localparam int LVL_W     = $clog2(CAP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WIDE_W-1:0]   in_data,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [NARROW_W-1:0] out_data,
    output logic [LVL_W-1:0]    level
);
    import w2n_pkg::*;

    localparam int                SEL_W    = idx_w(RATIO);
    localparam logic [LVL_W-1:0]  RATIO_L  = LVL_W'(RATIO);
    localparam logic [LVL_W-1:0]  CAP_L    = LVL_W'(CAP);
    localparam logic [LVL_W-1:0]  ROOM_LIM = CAP_L - RATIO_L;
    localparam logic [SEL_W-1:0]  LAST_L   = SEL_W'(RATIO - 1);

    logic                in_fire, out_fire;
    logic [SEL_W-1:0]    rd_lane;
    logic [RATIO-1:0]    lane_empty, lane_full, lane_pop;
    logic [NARROW_W-1:0] lane_dout [RATIO];
    logic                head_valid, head_pop_ok, head_pop;
    logic [NARROW_W-1:0] head_data;

    assign in_ready = (level <= ROOM_LIM);
    assign in_fire  = in_valid && in_ready;
    assign out_fire = out_valid && out_ready;

    // Lane FIFOs, one per narrow slice of the wide word.
    for (genvar g = 0; g < RATIO; g++) begin : g_lane
        assign lane_pop[g] = head_pop && (rd_lane == SEL_W'(g));
        w2n_lane_fifo #(.DATA_W(NARROW_W), .DEPTH(LANE_DEPTH)) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (in_fire),
            .push_data (in_data[g*NARROW_W +: NARROW_W]),
            .pop       (lane_pop[g]),
            .pop_data  (lane_dout[g]),
            .empty     (lane_empty[g]),
            .full      (lane_full[g])
        );
    end

    assign head_valid = !lane_empty[rd_lane];
    assign head_data  = lane_dout[rd_lane];
    assign head_pop   = head_valid && head_pop_ok;

    // Rotate the read lane on every pop, wrapping after the last lane.
    always_ff @(posedge clk) begin
        if (!rst_n)        rd_lane <= '0;
        else if (head_pop) rd_lane <= (rd_lane == LAST_L) ? '0 : rd_lane + 1'b1;
    end

    // Output path: registered slice or direct connection.
    if (SLICE_EN) begin : g_slice
        w2n_out_slice #(.DATA_W(NARROW_W)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_valid (head_valid),
            .up_ready (head_pop_ok),
            .up_data  (head_data),
            .dn_valid (out_valid),
            .dn_ready (out_ready),
            .dn_data  (out_data)
        );
    end else begin : g_direct
        assign out_valid   = head_valid;
        assign out_data    = head_data;
        assign head_pop_ok = out_ready;
    end

    // Count stored narrow elements: plus RATIO per write, minus one per read.
    always_ff @(posedge clk) begin
        if (!rst_n) level <= '0;
        else        level <= level + (in_fire ? RATIO_L : '0) - LVL_W'(out_fire);
    end

    // R3
    level_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) level <= CAP_L);
    // R3
    empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) (level == '0) |-> !out_valid);
    // R4
    room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_fire |-> (lane_full == '0) && (level <= ROOM_LIM));
    // R5
    hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R8
    lane_range_chk: assert property (@(posedge clk) disable iff (!rst_n) rd_lane <= LAST_L);
endmodule

// File: tb/wide2narrow_fifo_tb.sv
`timescale 1ns/1ps
module wide2narrow_fifo_tb;
    localparam int NW = 8, RT = 4, LD = 4;
    localparam int WW = NW * RT, CAPV = RT * LD, LW = $clog2(CAPV + 1);

    logic clk = 0, rst_n = 0;
    logic [1:0] iv = '0, ir, ov, ordy = '0;
    logic [WW-1:0] idat [2];
    logic [NW-1:0] odat [2];
    logic [LW-1:0] lvl [2];
    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;
    logic [NW-1:0] q0 [$], q1 [$];
    int model [2];
    bit stall_prev [2];
    logic [NW-1:0] dat_prev [2];
    int fire_cnt [2], first_c [2], last_c [2];

    always #4 clk = ~clk;

    wide2narrow_fifo #(.NARROW_W(NW), .RATIO(RT), .LANE_DEPTH(LD), .SLICE_EN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(iv[0]), .in_ready(ir[0]), .in_data(idat[0]),
        .out_valid(ov[0]), .out_ready(ordy[0]), .out_data(odat[0]), .level(lvl[0]));
    wide2narrow_fifo #(.NARROW_W(NW), .RATIO(RT), .LANE_DEPTH(LD), .SLICE_EN(1'b1)) u_dut_slc (
        .clk(clk), .rst_n(rst_n), .in_valid(iv[1]), .in_ready(ir[1]), .in_data(idat[1]),
        .out_valid(ov[1]), .out_ready(ordy[1]), .out_data(odat[1]), .level(lvl[1]));

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] word_of(input int base, input int k);
        logic [WW-1:0] w;
        for (int l = 0; l < RT; l++) w[l*NW +: NW] = NW'(base + k*RT + l);
        return w;
    endfunction

    always @(posedge clk) cyc <= cyc + 1;

    // Scoreboard and level model, sampled at the falling edge for the next rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 2; i++) begin
                chk($sformatf("R3 level model dut%0d", i), lvl[i], model[i]);
                if (stall_prev[i]) begin
                    chk($sformatf("R5 valid held dut%0d", i), ov[i], 1);
                    chk($sformatf("R5 data held dut%0d", i), odat[i], dat_prev[i]);
                end
                stall_prev[i] = ov[i] && !ordy[i];
                dat_prev[i]   = odat[i];
                if (ov[i] && ordy[i]) begin
                    logic [NW-1:0] e;
                    int sz;
                    sz = (i == 0) ? q0.size() : q1.size();
                    if (sz == 0) chk($sformatf("R7 no duplicate dut%0d", i), 1, 0);
                    else begin
                        e = (i == 0) ? q0.pop_front() : q1.pop_front();
                        chk($sformatf("R2 R8 order dut%0d", i), odat[i], e);
                    end
                    model[i]--;
                    fire_cnt[i]++;
                    if (fire_cnt[i] == 1) first_c[i] = cyc;
                    last_c[i] = cyc;
                end
                if (iv[i] && ir[i]) begin
                    for (int l = 0; l < RT; l++) begin
                        if (i == 0) q0.push_back(idat[i][l*NW +: NW]);
                        else        q1.push_back(idat[i][l*NW +: NW]);
                    end
                    model[i] += RT;
                end
            end
        end
    end

    task automatic send_burst(input int s, input int n, input int base);
        for (int k = 0; k < n; k++) begin
            idat[s] = word_of(base, k);
            iv[s] = 1'b1;
            do @(negedge clk); while (!ir[s]);
            @(posedge clk); #1;
        end
        iv[s] = 1'b0;
    endtask

    task automatic drain(input int s);
        ordy[s] = 1'b1;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            if (lvl[s] == 0 && !ov[s]) break;
        end
        @(posedge clk); #1;
        ordy[s] = 1'b0;
        chk($sformatf("R2 drain empty dut%0d", s), (s == 0) ? q0.size() : q1.size(), 0);
        chk($sformatf("R3 drain level dut%0d", s), lvl[s], 0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            chk("R1 out_valid", ov[s], 0);
            chk("R1 level", lvl[s], 0);
            chk("R1 in_ready", ir[s], 1);
        end
    endtask

    task automatic t_latency(input int s);
        @(posedge clk); #1;
        idat[s] = word_of(8'h10, 0);
        iv[s] = 1'b1;
        @(posedge clk); #1;
        iv[s] = 1'b0;
        @(negedge clk);
        chk($sformatf("R6 first valid dut%0d", s), ov[s], (s == 0) ? 1 : 0);
        chk($sformatf("R6 level counts word dut%0d", s), lvl[s], RT);
        @(negedge clk);
        chk($sformatf("R6 valid later dut%0d", s), ov[s], 1);
        chk($sformatf("R6 level with slice dut%0d", s), lvl[s], RT);
        drain(s);
    endtask

    task automatic t_fill(input int s);
        send_burst(s, LD, 8'h20);
        @(negedge clk);
        chk($sformatf("R4 full level dut%0d", s), lvl[s], CAPV);
        chk($sformatf("R4 ready low when full dut%0d", s), ir[s], 0);
        idat[s] = '1;
        iv[s] = 1'b1;
        repeat (3) @(posedge clk);
        #1 iv[s] = 1'b0;
        @(negedge clk);
        chk($sformatf("R4 ignored write dut%0d", s), lvl[s], CAPV);
        for (int p = 1; p <= RT; p++) begin
            @(posedge clk); #1 ordy[s] = 1'b1;
            @(posedge clk); #1 ordy[s] = 1'b0;
            @(negedge clk);
            chk($sformatf("R4 pop level dut%0d", s), lvl[s], CAPV - p);
            chk($sformatf("R4 room ready dut%0d", s), ir[s], (p >= RT) ? 1 : 0);
        end
        drain(s);
    endtask

    task automatic t_simul(input int s);
        send_burst(s, 1, 8'h40);
        do @(negedge clk); while (!ov[s]);
        @(posedge clk); #1;
        idat[s] = word_of(8'h50, 0);
        iv[s] = 1'b1;
        ordy[s] = 1'b1;
        @(negedge clk);
        chk($sformatf("R3 both fire setup dut%0d", s), ir[s] && ov[s], 1);
        @(posedge clk); #1;
        iv[s] = 1'b0;
        ordy[s] = 1'b0;
        @(negedge clk);
        chk($sformatf("R3 net change dut%0d", s), lvl[s], 2 * RT - 1);
        drain(s);
    endtask

    task automatic t_stream(input int s);
        fire_cnt[s] = 0;
        ordy[s] = 1'b1;
        send_burst(s, 8, 8'h60);
        drain(s);
        chk($sformatf("R7 element count dut%0d", s), fire_cnt[s], 8 * RT);
        chk($sformatf("R7 no gaps dut%0d", s), last_c[s] - first_c[s] + 1, 8 * RT);
    endtask

    task automatic t_backpressure(input int s);
        fork
            send_burst(s, 6, 8'h90);
            for (int k = 0; k < 60; k++) begin
                @(posedge clk); #1;
                ordy[s] = ((k % 3) != 0) && ((k % 7) != 5);
            end
        join
        drain(s);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        idat[0] = '0; idat[1] = '0;
        model[0] = 0; model[1] = 0;
        stall_prev[0] = 0; stall_prev[1] = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        for (int s = 0; s < 2; s++) begin
            t_latency(s);
            t_fill(s);
            t_simul(s);
            t_stream(s);
            t_backpressure(s);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule